// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the general-purpose registers of a processor core that switches between several operating modes. Software sees sixteen logical registers in every mode. They are stored in thirty-two physical entries. Some modes get private copies of some registers: entering an exception mode then does not overwrite the values that the interrupted code was using. Every access turns its 4-bit logical index and the current 5-bit mode into a 5-bit physical index, and then reads or writes that entry.

There are two combinational read ports and one clocked write port. Each port has its own user-view flag. When the flag is set, that port uses the user-mode mapping whatever the current mode is. Privileged code uses this to save or restore the registers of an interrupted user task. Logical 14 holds the return link, and logical 15 is the program counter, which always sits in physical entry 15. The fast-interrupt mode has private copies of logical 8 to 14. The other exception modes have private copies of logical 13 and 14 only.

Mode codes used at the `cur_mode` input: user 5'b10000, system 5'b11111, supervisor 5'b10011, abort 5'b10111, undefined 5'b11011, interrupt 5'b10010, fast interrupt 5'b10001.

Top module: `rfb_regfile`

## Requirements
- R1: Logical indices 0 to 7 reach the same physical entry in every mode, so a value written in one mode reads back in any other mode.
- R2: Logical 15 (the program counter) maps to physical entry 15 in every mode.
- R3: In fast-interrupt mode (5'b10001), logical 8 to 14 map to physical 16 to 22 in order. They are therefore separate from the user copies of those registers and from the other modes' copies of 13 and 14.
- R4: Logical 13 and 14 map to physical 24/25 in supervisor mode, 26/27 in abort mode, 28/29 in undefined mode and 30/31 in interrupt mode. These pairs are separate from each other and from the user copies.
- R5: In supervisor, abort, undefined and interrupt modes, logical 8 to 12 share the user entries.
- R6: User mode, system mode and any unlisted mode code all use the identity mapping, with physical index equal to logical index.
- R7: When a port's user-view flag is set, that port uses the identity mapping whatever the current mode is.
- R8: No mode selects physical entry 23 and no write ever lands there. The other 31 entries are all reachable and distinct.
- R9: Reads are combinational. A read of the entry being written returns the old value until the clock edge and the new value after it.
- R10: A synchronous active-high reset clears every entry to zero.
- R11: While the write enable is low, no entry changes, whatever the write index and data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_mode | input | 5 | Current operating mode code |
| rd_a_idx | input | 4 | Read port A logical index |
| rd_a_user | input | 1 | Read port A user-view flag |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_idx | input | 4 | Read port B logical index |
| rd_b_user | input | 1 | Read port B user-view flag |
| rd_b_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write logical index |
| wr_user | input | 1 | Write port user-view flag |
| wr_data | input | DATA_W | Write data |

## Verification
A wrong index mapping does not show up when it happens. It shows up as aliasing later on. A write made in one mode appears, or fails to appear, on a read made in another mode, and only after the write's clock edge. The bench therefore writes a unique value through one mode and index and reads the same cycle's result back through a second mode and index. Whether the two accesses share an entry or not shows at the read ports after one clock. Filling every reachable entry with a distinct value and reading each one back exposes any two mappings that collapse onto one entry. It also exposes any mapping that strays onto entry 23.

// File: rtl/rfb_pkg.sv
package rfb_pkg;

    localparam int LIDX_W      = 4;
    localparam int PIDX_W      = LIDX_W + 1;
    localparam int NUM_PHYS    = 1 << PIDX_W;
    localparam int PC_SLOT     = 15;
    localparam int LINK_SLOT   = 14;
    localparam int STACK_SLOT  = 13;
    localparam int FAST_LO     = 8;
    localparam int FAST_OFFSET = 8;
    localparam int HOLE_SLOT   = 23;

    typedef logic [LIDX_W-1:0] lidx_t;
    typedef logic [PIDX_W-1:0] pidx_t;

    typedef enum logic [4:0] {
        MD_USER  = 5'b10000,
        MD_SYS   = 5'b11111,
        MD_SUPV  = 5'b10011,
        MD_ABORT = 5'b10111,
        MD_UNDEF = 5'b11011,
        MD_INTR  = 5'b10010,
        MD_FAST  = 5'b10001
    } mode_e;

    typedef struct packed {
        lidx_t idx;
        logic  user;
    } port_req_t;

    // Base of the private pair (stack, link) for the single-pair modes.
    function automatic pidx_t pair_base(input logic [4:0] mode);
        pidx_t b;
        case (mode)
            MD_SUPV:  b = pidx_t'(24);
            MD_ABORT: b = pidx_t'(26);
            MD_UNDEF: b = pidx_t'(28);
            MD_INTR:  b = pidx_t'(30);
            default:  b = '0;
        endcase
        return b;
    endfunction

    function automatic logic has_pair(input logic [4:0] mode);
        return (mode == MD_SUPV) || (mode == MD_ABORT) ||
               (mode == MD_UNDEF) || (mode == MD_INTR);
    endfunction

    // Logical-to-physical translation for one access.
    function automatic pidx_t to_phys(input logic [4:0] mode,
                                      input lidx_t idx,
                                      input logic user);
        pidx_t r;
        r = {1'b0, idx};
        if (!user) begin
            if (mode == MD_FAST) begin
                if (idx >= lidx_t'(FAST_LO) && idx <= lidx_t'(LINK_SLOT))
                    r = {1'b0, idx} + pidx_t'(FAST_OFFSET);
            end else if (has_pair(mode)) begin
                if (idx == lidx_t'(STACK_SLOT))
                    r = pair_base(mode);
                else if (idx == lidx_t'(LINK_SLOT))
                    r = pair_base(mode) + pidx_t'(1);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/rfb_index_map.sv
module rfb_index_map
    import rfb_pkg::*;
(
    input  logic [4:0] mode,
    input  port_req_t  req,
    output pidx_t      phys
);

    always_comb begin
        phys = to_phys(mode, req.idx, req.user);
    end

    always_comb begin
        // R1: low registers never move
        if (req.idx < lidx_t'(8))
            a_r1_low_shared: assert (phys == {1'b0, req.idx});
        // R2: program counter fixed
        if (req.idx == lidx_t'(PC_SLOT))
            a_r2_pc_fixed: assert (phys == pidx_t'(PC_SLOT));
        // R7: user view forces identity
        if (req.user)
            a_r7_user_view: assert (phys == {1'b0, req.idx});
        // R8: hole never selected
        a_r8_no_hole: assert (phys != pidx_t'(HOLE_SLOT));
    end

endmodule

// File: rtl/rfb_bank_store.sv
module rfb_bank_store
    import rfb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NUM_RD = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           we,
    input  pidx_t                          waddr,
    input  logic [DATA_W-1:0]              wdata,
    input  pidx_t [NUM_RD-1:0]             raddr,
    output logic  [NUM_RD-1:0][DATA_W-1:0] rdata
);

    logic [NUM_PHYS-1:0][DATA_W-1:0] mem;

    always_ff @(posedge clk) begin
        if (rst)
            mem <= '0;
        else if (we)
            mem[waddr] <= wdata;
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        assign rdata[p] = mem[raddr[p]];
    end

    // R8: no write reaches the unmapped entry
    a_r8_hole_untouched: assert property (@(posedge clk) disable iff (rst)
        we |-> waddr != pidx_t'(HOLE_SLOT));

    // R9: written entry holds the new data after the edge
    a_r9_write_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> mem[$past(waddr)] == $past(wdata));

    // R10: reset clears everything
    a_r10_reset_clear: assert property (@(posedge clk)
        rst |=> mem == '0);

    // R11: idle write port leaves storage alone
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(mem));

endmodule

// File: rtl/rfb_regfile.sv
module rfb_regfile
    import rfb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        cur_mode,
    input  logic [3:0]        rd_a_idx,
    input  logic              rd_a_user,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_idx,
    input  logic              rd_b_user,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic              wr_user,
    input  logic [DATA_W-1:0] wr_data
);

    localparam int NUM_RD    = 2;
    localparam int NUM_PORTS = NUM_RD + 1;
    localparam int WR_PORT   = NUM_RD;

    port_req_t [NUM_PORTS-1:0] reqs;
    pidx_t     [NUM_PORTS-1:0] phys;
    pidx_t     [NUM_RD-1:0]    rd_phys;
    logic      [NUM_RD-1:0][DATA_W-1:0] rd_vals;

    assign reqs[0]       = '{idx: rd_a_idx, user: rd_a_user};
    assign reqs[1]       = '{idx: rd_b_idx, user: rd_b_user};
    assign reqs[WR_PORT] = '{idx: wr_idx,   user: wr_user};

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_map
        rfb_index_map u_map (
            .mode (cur_mode),
            .req  (reqs[p]),
            .phys (phys[p])
        );
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rsel
        assign rd_phys[p] = phys[p];
    end

    rfb_bank_store #(
        .DATA_W (DATA_W),
        .NUM_RD (NUM_RD)
    ) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .waddr (phys[WR_PORT]),
        .wdata (wr_data),
        .raddr (rd_phys),
        .rdata (rd_vals)
    );

    assign rd_a_data = rd_vals[0];
    assign rd_b_data = rd_vals[1];

    // R1: both read ports agree when asking for the same low register
    a_r1_ports_agree: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx == rd_b_idx && rd_a_idx < 4'd8) |-> rd_a_data == rd_b_data);

endmodule

// File: tb/rfb_regfile_test.sv
module rfb_regfile_test;
    import rfb_pkg::*;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic [4:0]    cur_mode;
    logic [3:0]    rd_a_idx, rd_b_idx, wr_idx;
    logic          rd_a_user, rd_b_user, wr_user, wr_en;
    logic [DW-1:0] rd_a_data, rd_b_data, wr_data;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #4 clk = ~clk; // 125 MHz

    rfb_regfile #(.DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .cur_mode(cur_mode),
        .rd_a_idx(rd_a_idx), .rd_a_user(rd_a_user), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_user(rd_b_user), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_user(wr_user), .wr_data(wr_data)
    );

    localparam logic [4:0] U  = 5'b10000, S  = 5'b11111, SV = 5'b10011,
                           AB = 5'b10111, UN = 5'b11011, IQ = 5'b10010,
                           FQ = 5'b10001, BAD = 5'b00101;

    typedef struct packed {
        logic [4:0] wm;
        logic [3:0] wi;
        logic [4:0] rm;
        logic [3:0] ri;
        logic       shared;
        logic [3:0] req;
    } vec_t;

    // write via (wm,wi), read via (rm,ri); shared=1 means same entry
    localparam vec_t VEC [15] = '{
        '{FQ,  4'd3,  U,  4'd3,  1'b1, 4'd1},  // R1
        '{SV,  4'd7,  IQ, 4'd7,  1'b1, 4'd1},  // R1
        '{UN,  4'd15, FQ, 4'd15, 1'b1, 4'd2},  // R2
        '{FQ,  4'd8,  U,  4'd8,  1'b0, 4'd3},  // R3
        '{FQ,  4'd8,  FQ, 4'd8,  1'b1, 4'd3},  // R3
        '{FQ,  4'd14, SV, 4'd14, 1'b0, 4'd3},  // R3
        '{FQ,  4'd12, IQ, 4'd12, 1'b0, 4'd3},  // R3
        '{SV,  4'd13, AB, 4'd13, 1'b0, 4'd4},  // R4
        '{AB,  4'd14, UN, 4'd14, 1'b0, 4'd4},  // R4
        '{IQ,  4'd13, U,  4'd13, 1'b0, 4'd4},  // R4
        '{UN,  4'd13, UN, 4'd13, 1'b1, 4'd4},  // R4
        '{SV,  4'd10, U,  4'd10, 1'b1, 4'd5},  // R5
        '{IQ,  4'd9,  AB, 4'd9,  1'b1, 4'd5},  // R5
        '{S,   4'd13, U,  4'd13, 1'b1, 4'd6},  // R6
        '{BAD, 4'd14, U,  4'd14, 1'b1, 4'd6}   // R6
    };

    task automatic check_eq(input string req, input logic [DW-1:0] act,
                            input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_ne(input string req, input logic [DW-1:0] act,
                            input logic [DW-1:0] notexp);
        checks++;
        if (act === notexp) begin
            errors++;
            $display("FAIL %s: actual=%h expected anything but %h", req, act, notexp);
        end
    endtask

    task automatic do_write(input logic [4:0] m, input logic [3:0] i,
                            input logic u, input logic [DW-1:0] d);
        @(negedge clk);
        cur_mode = m; wr_idx = i; wr_user = u; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [4:0] m, input logic [3:0] i,
                           input logic u);
        cur_mode = m;
        rd_a_idx = i; rd_a_user = u;
        rd_b_idx = i; rd_b_user = u;
        #1;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cur_mode = U; wr_en = 1'b0; wr_idx = '0; wr_user = 1'b0;
        wr_data = '0; rd_a_idx = '0; rd_b_idx = '0; rd_a_user = 1'b0; rd_b_user = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10: reset state
        do_read(U, 4'd0, 1'b0);
        check_eq("R10 reset r0", rd_a_data, '0);
        do_read(FQ, 4'd13, 1'b0);
        check_eq("R10 reset fast r13", rd_b_data, '0);

        // table walk
        foreach (VEC[k]) begin
            logic [DW-1:0] d;
            string tag;
            d = 32'hA000_0000 + DW'(k);
            tag = $sformatf("R%0d vec%0d", VEC[k].req, k);
            do_write(VEC[k].wm, VEC[k].wi, 1'b0, d);
            do_read(VEC[k].rm, VEC[k].ri, 1'b0);
            if (VEC[k].shared) begin
                check_eq(tag, rd_a_data, d);
                check_eq(tag, rd_b_data, d);
            end else begin
                check_ne(tag, rd_a_data, d);
            end
        end

        // R7: write port user view in fast mode lands in user r9
        do_write(FQ, 4'd9, 1'b1, 32'h7777_0009);
        do_read(U, 4'd9, 1'b0);
        check_eq("R7 write user view", rd_a_data, 32'h7777_0009);
        do_read(FQ, 4'd9, 1'b0);
        check_ne("R7 fast copy untouched", rd_a_data, 32'h7777_0009);
        // R7: read ports user view from interrupt mode
        do_write(U, 4'd13, 1'b0, 32'h7777_000D);
        cur_mode = IQ; rd_a_idx = 4'd13; rd_a_user = 1'b1;
        rd_b_idx = 4'd13; rd_b_user = 1'b0; #1;
        check_eq("R7 read A user view", rd_a_data, 32'h7777_000D);
        check_ne("R7 read B banked", rd_b_data, 32'h7777_000D);
        rd_b_user = 1'b1; #1;
        check_eq("R7 read B user view", rd_b_data, 32'h7777_000D);

        // R9: same-cycle read sees old, next cycle sees new
        do_write(U, 4'd5, 1'b0, 32'h1111_0005);
        @(negedge clk);
        cur_mode = U; wr_idx = 4'd5; wr_user = 1'b0; wr_data = 32'h2222_0005;
        wr_en = 1'b1; rd_a_idx = 4'd5; rd_a_user = 1'b0; #1;
        check_eq("R9 old value before edge", rd_a_data, 32'h1111_0005);
        @(posedge clk); #1;
        check_eq("R9 new value after edge", rd_a_data, 32'h2222_0005);
        @(negedge clk); wr_en = 1'b0;

        // R11: idle write port
        @(negedge clk);
        cur_mode = U; wr_idx = 4'd5; wr_data = 32'hDEAD_BEEF; wr_en = 1'b0;
        @(negedge clk);
        do_read(U, 4'd5, 1'b0);
        check_eq("R11 no write when disabled", rd_a_data, 32'h2222_0005);

        // R8: fill all 31 reachable entries with distinct values, read back
        for (int i = 0; i < 16; i++) do_write(U, 4'(i), 1'b0, 32'h100 + i);
        for (int i = 8; i < 15; i++) do_write(FQ, 4'(i), 1'b0, 32'h200 + i);
        for (int m = 0; m < 4; m++) begin
            logic [4:0] mc;
            mc = (m == 0) ? SV : (m == 1) ? AB : (m == 2) ? UN : IQ;
            do_write(mc, 4'd13, 1'b0, 32'h300 + 2 * m);
            do_write(mc, 4'd14, 1'b0, 32'h301 + 2 * m);
        end
        for (int i = 0; i < 16; i++) begin
            do_read(U, 4'(i), 1'b0);
            check_eq($sformatf("R8 user r%0d", i), rd_a_data, 32'h100 + i);
        end
        for (int i = 8; i < 15; i++) begin
            do_read(FQ, 4'(i), 1'b0);
            check_eq($sformatf("R8 fast r%0d", i), rd_a_data, 32'h200 + i);
        end
        for (int m = 0; m < 4; m++) begin
            logic [4:0] mc;
            mc = (m == 0) ? SV : (m == 1) ? AB : (m == 2) ? UN : IQ;
            do_read(mc, 4'd13, 1'b0);
            check_eq("R8 pair stack", rd_a_data, 32'h300 + 2 * m);
            do_read(mc, 4'd14, 1'b0);
            check_eq("R8 pair link", rd_a_data, 32'h301 + 2 * m);
        end

        // R10: reset in the middle of operation
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        do_read(U, 4'd15, 1'b0);
        check_eq("R10 reset pc", rd_a_data, '0);
        do_read(IQ, 4'd14, 1'b0);
        check_eq("R10 reset irq link", rd_a_data, '0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule